// File: doc/BRIEF.md
# Sleep Wakeup Power Sequencer

This controller brings a sleeping low-power core back to operation. While asleep, it watches a vector of interrupt requests against an enable mask. The first unmasked pending request starts a wakeup. The CPU's global interrupt flag plays no part in this decision. The analog supplies (regulator, bandgap, low-speed oscillator, power-on/low-voltage detector and main oscillator) are switched on combinationally in the same cycle the request is seen, without waiting for a clock edge.

From then on, the sequencer counts cycles of the main oscillator clock through four timed phases. Each phase lasts 2^N cycles, where N is a 3-bit tap field for that phase. At the end of the oscillator-startup phase, the bandgap status is captured and the flash is powered. The next phase puts the flash into its idle mode. At the end of the third phase, the power-on/low-voltage detector status is sampled. If it is good, the CPU is released. If it shows a fault, a system reset request is raised instead. A completion flag goes high when the fourth phase ends, and peripheral gating may use it.

A sleep request returns the block to the asleep state. The interrupt itself is left pending, because vectoring and servicing are outside this block.

Top module: `wake_seq_ctrl`

## Requirements
- R1: A wakeup starts only when the block is asleep and at least one bit of `irq_req & irq_en` is 1. Requests whose enable bit is 0 have no effect.
- R2: While asleep, `pwr_analog_en` goes to 1 combinationally in the same cycle an unmasked request appears with `sleep_req` low. It stays at 1 in every state other than asleep.
- R3: Phase i (0 = oscillator startup, 1 = flash power-up, 2 = flash idle, 3 = CPU start) lasts exactly 2^N clock cycles. N is `phase_tap[3*i+2:3*i]`.
- R4: At the end of phase 0, `flash_en` goes to 1 and `bg_good` captures `bandgap_ok`. `bg_good` is 0 before that point.
- R5: `flash_idle` is 1 during phase 2 and only then. `flash_en` stays at 1 from phase 1 until the sequence leaves for sleep or fault.
- R6: At the end of phase 2, if `porlvd_ok` is 1, `cpu_run` goes to 1.
- R7: If `porlvd_ok` is 0 at the end of phase 2, `sys_rst_req` goes to 1, and `cpu_run` and `flash_en` stay at 0.
- R8: `wake_done` goes to 1 when phase 3 ends. It stays at 1, together with `cpu_run`, until a sleep request arrives.
- R9: When `sleep_req` is 1 in any state other than fault, the block is asleep after the next clock edge, with every output at 0. While `sleep_req` is 1 in the asleep state, no wakeup starts.
- R10: The fault state holds `sys_rst_req` at 1 until `rst_n` goes low. `sleep_req` has no effect on it.
- R11: After a synchronous reset (`rst_n` low), the block is asleep and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Interrupt enable mask, 1 = enabled |
| sleep_req | input | 1 | Return-to-sleep request |
| phase_tap | input | 4*TAP_W | Tap field for each phase; phase i uses bits [TAP_W*i +: TAP_W] |
| bandgap_ok | input | 1 | Bandgap settled status |
| porlvd_ok | input | 1 | Power-on/low-voltage detector status, 1 = supply good |
| pwr_analog_en | output | 1 | Enable for regulator, bandgap, low-speed oscillator, detector and main oscillator |
| flash_en | output | 1 | Flash power enable |
| flash_idle | output | 1 | Flash low-power idle mode |
| cpu_run | output | 1 | CPU released from halt |
| sys_rst_req | output | 1 | System reset request after a supply fault |
| bg_good | output | 1 | Bandgap status captured at the end of phase 0 |
| wake_done | output | 1 | Wakeup sequence complete |

## Verification
The analog enable has no register in its path, so the bench samples it one time unit after driving the request, before any clock edge. Every other result comes from the state register. The bench counts edges from the trigger edge. With phase lengths L0..L3, the sample taken k edges after the trigger belongs to phase 0 while k < L0, phase 1 while k < L0+L1, and so on. `cpu_run` or `sys_rst_req` first shows at k = L0+L1+L2, and `wake_done` first shows at k = L0+L1+L2+L3. Every output is compared at each falling edge across the whole sequence, so a boundary that is off by one cycle is reported. A sleep request takes effect at the first falling edge after the edge that registers it.

// File: rtl/wake_seq_pkg.sv
// Shared types for the wakeup sequencer.
// Assumes: four timed phases, one state per phase plus asleep, done and fault.
package wake_seq_pkg;
    localparam int NUM_PHASES = 4;

    typedef enum logic [2:0] {
        WS_SLEEP      = 3'd0,
        WS_OSC        = 3'd1,
        WS_FLASH_ON   = 3'd2,
        WS_FLASH_IDLE = 3'd3,
        WS_CPU_START  = 3'd4,
        WS_DONE       = 3'd5,
        WS_FAULT      = 3'd6
    } wake_state_t;
endpackage

// File: rtl/wake_detect.sv
// Wake condition detector: flags any interrupt request whose enable bit is set.
// Assumes: requests are already synchronous to clk, or are only used as an
// asynchronous power-up trigger.
module wake_detect #(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               wake_hit
);
    logic [NUM_IRQ-1:0] qualified;

    // Per-source qualification of request by its enable bit.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        assign qualified[g] = irq_req[g] & irq_en[g];
    end

    // Any qualified source wakes the core.
    assign wake_hit = |qualified;
endmodule

// File: rtl/phase_timer.sv
// Wakeup timer: counts clock cycles within the current phase and pulses tick
// on the last cycle of a phase that is 2^N cycles long.
// Assumes: the count restarts from zero whenever run is low or a phase ends.
module phase_timer #(
    parameter int TAP_W      = 3,
    parameter int NUM_PHASES = 4,
    localparam int PH_W      = $clog2(NUM_PHASES),
    localparam int CNT_W     = (1 << TAP_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [PH_W-1:0]             phase_idx,
    input  logic [NUM_PHASES*TAP_W-1:0] phase_tap,
    output logic                        tick
);
    logic [TAP_W-1:0] tap_of [NUM_PHASES];
    logic [TAP_W-1:0] tap_sel;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    // Split the packed tap vector into one field per phase.
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_tap
        assign tap_of[p] = phase_tap[p*TAP_W +: TAP_W];
    end

    // Terminal count of the selected phase.
    always_comb begin
        tap_sel = tap_of[phase_idx];
        limit   = (CNT_W'(1) << tap_sel) - CNT_W'(1);
    end

    assign tick = run && (cnt == limit);

    // Cycle counter, cleared between phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit))
        else $error("phase counter passed its terminal count");
endmodule

// File: rtl/wake_fsm.sv
// Wakeup sequence state machine: walks the asleep -> oscillator -> flash on ->
// flash idle -> CPU start -> done path, branching to fault on a bad supply.
// Assumes: tick comes from phase_timer and marks the last cycle of a phase.
module wake_fsm
    import wake_seq_pkg::*;
#(
    parameter int NUM_PHASES = 4,
    localparam int PH_W      = $clog2(NUM_PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wake_hit,
    input  logic            sleep_req,
    input  logic            tick,
    input  logic            bandgap_ok,
    input  logic            porlvd_ok,
    output wake_state_t     state,
    output logic [PH_W-1:0] phase_idx,
    output logic            timing_run,
    output logic            bg_good
);
    wake_state_t nxt;

    // Next-state decision; sleep has priority except in fault.
    always_comb begin
        nxt = state;
        unique case (state)
            WS_SLEEP:      if (wake_hit && !sleep_req) nxt = WS_OSC;
            WS_OSC:        if (tick) nxt = WS_FLASH_ON;
            WS_FLASH_ON:   if (tick) nxt = WS_FLASH_IDLE;
            WS_FLASH_IDLE: if (tick) nxt = porlvd_ok ? WS_CPU_START : WS_FAULT;
            WS_CPU_START:  if (tick) nxt = WS_DONE;
            WS_DONE:       nxt = WS_DONE;
            WS_FAULT:      nxt = WS_FAULT;
            default:       nxt = WS_SLEEP;
        endcase
        if (sleep_req && state != WS_FAULT) nxt = WS_SLEEP;
    end

    // Which tap field times the current state.
    always_comb begin
        timing_run = 1'b1;
        phase_idx  = '0;
        unique case (state)
            WS_OSC:        phase_idx = PH_W'(0);
            WS_FLASH_ON:   phase_idx = PH_W'(1);
            WS_FLASH_IDLE: phase_idx = PH_W'(2);
            WS_CPU_START:  phase_idx = PH_W'(3);
            default:       timing_run = 1'b0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_SLEEP;
        else        state <= nxt;
    end

    // Bandgap capture at the end of the oscillator phase.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt == WS_SLEEP) bg_good <= 1'b0;
        else if (state == WS_OSC && tick) bg_good <= bandgap_ok;
    end

    a_r6_run_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_CPU_START && $past(state) == WS_FLASH_IDLE) |-> $past(porlvd_ok))
        else $error("CPU started without a good supply sample");

    a_r9_sleep_next: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && state != WS_FAULT) |=> state == WS_SLEEP)
        else $error("sleep request not honoured");

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state == WS_FAULT |=> state == WS_FAULT)
        else $error("fault state left without reset");

    a_r1_wake_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_OSC && $past(state) == WS_SLEEP) |-> $past(wake_hit))
        else $error("wakeup without an enabled request");
endmodule

// File: rtl/wake_seq_ctrl.sv
// Sleep wakeup power sequencer top: combines wake detection, the phase timer
// and the state machine, and decodes the power and CPU controls.
// Assumes: clk is the main oscillator clock; analog enables must rise before
// that clock runs, so they are driven combinationally from the request.
module wake_seq_ctrl
    import wake_seq_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int TAP_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_IRQ-1:0]          irq_req,
    input  logic [NUM_IRQ-1:0]          irq_en,
    input  logic                        sleep_req,
    input  logic [NUM_PHASES*TAP_W-1:0] phase_tap,
    input  logic                        bandgap_ok,
    input  logic                        porlvd_ok,
    output logic                        pwr_analog_en,
    output logic                        flash_en,
    output logic                        flash_idle,
    output logic                        cpu_run,
    output logic                        sys_rst_req,
    output logic                        bg_good,
    output logic                        wake_done
);
    localparam int PH_W = $clog2(NUM_PHASES);

    logic            wake_hit;
    logic            tick;
    logic            timing_run;
    logic [PH_W-1:0] phase_idx;
    wake_state_t     state;

    wake_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .wake_hit (wake_hit)
    );

    phase_timer #(.TAP_W(TAP_W), .NUM_PHASES(NUM_PHASES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (timing_run),
        .phase_idx (phase_idx),
        .phase_tap (phase_tap),
        .tick      (tick)
    );

    wake_fsm #(.NUM_PHASES(NUM_PHASES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_hit   (wake_hit),
        .sleep_req  (sleep_req),
        .tick       (tick),
        .bandgap_ok (bandgap_ok),
        .porlvd_ok  (porlvd_ok),
        .state      (state),
        .phase_idx  (phase_idx),
        .timing_run (timing_run),
        .bg_good    (bg_good)
    );

    // Output decode from the registered state; analog enable also from the request.
    always_comb begin
        pwr_analog_en = (state != WS_SLEEP) || (wake_hit && !sleep_req);
        flash_en      = (state == WS_FLASH_ON) || (state == WS_FLASH_IDLE) ||
                        (state == WS_CPU_START) || (state == WS_DONE);
        flash_idle    = (state == WS_FLASH_IDLE);
        cpu_run       = (state == WS_CPU_START) || (state == WS_DONE);
        sys_rst_req   = (state == WS_FAULT);
        wake_done     = (state == WS_DONE);
    end

    a_r2_analog_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WS_SLEEP) |-> pwr_analog_en)
        else $error("analog enable dropped while awake");

    a_r5_cpu_after_flash: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> flash_en && !flash_idle)
        else $error("CPU running without active flash");

    a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_done) |-> $past(cpu_run))
        else $error("completion without a CPU start phase");

    a_r7_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> !cpu_run && !flash_en)
        else $error("reset request together with CPU run");
endmodule

// File: tb/test_wake_seq_ctrl.sv
// Self-checking bench: directed corners plus seeded random wakeup sequences.
module test_wake_seq_ctrl;
    localparam int NUM_IRQ = 8;
    localparam int TAP_W   = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NUM_IRQ-1:0]     irq_req = '0;
    logic [NUM_IRQ-1:0]     irq_en = '0;
    logic                   sleep_req = 1'b0;
    logic [4*TAP_W-1:0]     phase_tap = '0;
    logic                   bandgap_ok = 1'b0;
    logic                   porlvd_ok = 1'b0;
    logic pwr_analog_en, flash_en, flash_idle, cpu_run, sys_rst_req, bg_good, wake_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wake_seq_ctrl #(.NUM_IRQ(NUM_IRQ), .TAP_W(TAP_W)) i_wake_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .sleep_req(sleep_req), .phase_tap(phase_tap), .bandgap_ok(bandgap_ok),
        .porlvd_ok(porlvd_ok), .pwr_analog_en(pwr_analog_en), .flash_en(flash_en),
        .flash_idle(flash_idle), .cpu_run(cpu_run), .sys_rst_req(sys_rst_req),
        .bg_good(bg_good), .wake_done(wake_done)
    );

    // Output bundle: {analog, flash_en, flash_idle, cpu_run, sys_rst_req, wake_done}
    function automatic logic [5:0] outs();
        return {pwr_analog_en, flash_en, flash_idle, cpu_run, sys_rst_req, wake_done};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs k edges after the trigger edge.
    function automatic logic [5:0] exp_outs(input int k, input int l0, input int l1,
                                            input int l2, input int l3, input logic por);
        if (k < l0)                 return 6'b100000;
        if (k < l0 + l1)            return 6'b110000;
        if (k < l0 + l1 + l2)       return 6'b111000;
        if (!por)                   return 6'b100010;
        if (k < l0 + l1 + l2 + l3)  return 6'b110100;
        return 6'b110101;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_req = '0; sleep_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic go_sleep();
        @(negedge clk);
        sleep_req = 1'b1; irq_req = '0;
        @(negedge clk);
        chk("R9 sleep clears outputs", {1'b0, bg_good, outs()}, 8'h00);
        sleep_req = 1'b0;
    endtask

    // One full wakeup with given taps; checks every cycle.
    task automatic run_wake(input logic [2:0] t0, input logic [2:0] t1, input logic [2:0] t2,
                            input logic [2:0] t3, input logic bg, input logic por);
        int l0, l1, l2, l3, total;
        int b;
        l0 = 1 << t0; l1 = 1 << t1; l2 = 1 << t2; l3 = 1 << t3;
        total = l0 + l1 + l2 + l3;
        @(negedge clk);
        phase_tap = {t3, t2, t1, t0};
        bandgap_ok = bg; porlvd_ok = por;
        b = $urandom_range(NUM_IRQ - 1);
        irq_en = NUM_IRQ'($urandom) | (NUM_IRQ'(1) << b);
        irq_req = (NUM_IRQ'($urandom) & ~irq_en) | (NUM_IRQ'(1) << b);
        #1;
        chk("R2 analog enable before clock", {2'b0, outs()}, 8'b00100000);
        @(posedge clk);
        for (int k = 0; k <= total + 2; k++) begin
            @(negedge clk);
            chk("R3/R4/R5/R6/R7/R8 phase outputs", {2'b0, outs()},
                {2'b0, exp_outs(k, l0, l1, l2, l3, por)});
            chk("R4 bandgap capture", {7'b0, bg_good}, {7'b0, (k >= l0) ? bg : 1'b0});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        @(negedge clk);
        chk("R11 reset state", {1'b0, bg_good, outs()}, 8'h00);

        // R1: masked request only -> no wake
        irq_req = 8'hF0; irq_en = 8'h0F;
        #1 chk("R1 masked no analog", {7'b0, pwr_analog_en}, 8'h00);
        repeat (5) @(negedge clk);
        chk("R1 masked stays asleep", {2'b0, outs()}, 8'h00);

        // R9: sleep_req held blocks wakeup
        sleep_req = 1'b1; irq_en = 8'hFF;
        repeat (4) @(negedge clk);
        chk("R9 sleep blocks wake", {2'b0, outs()}, 8'h00);
        sleep_req = 1'b0; irq_req = '0;

        // Shortest sequence, then longest-tap corner on phase 0
        run_wake(3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1);
        go_sleep();
        run_wake(3'd7, 3'd1, 3'd2, 3'd0, 1'b0, 1'b1);
        go_sleep();

        // R9: sleep mid-sequence
        run_wake(3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1);
        go_sleep();
        @(negedge clk);
        phase_tap = {4{3'd4}}; irq_en = 8'h01; irq_req = 8'h01;
        repeat (20) @(negedge clk);
        chk("R9 mid-sequence awake", {2'b0, outs()}, 8'b00110000);
        go_sleep();

        // R7 / R10: supply fault, sleep ignored
        run_wake(3'd1, 3'd1, 3'd1, 3'd1, 1'b1, 1'b0);
        @(negedge clk);
        sleep_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 fault holds through sleep", {2'b0, outs()}, 8'b00100010);
        sleep_req = 1'b0;
        do_reset();
        @(negedge clk);
        chk("R11 reset clears fault", {1'b0, bg_good, outs()}, 8'h00);

        // Random sequences
        for (int n = 0; n < 24; n++) begin
            run_wake(3'($urandom_range(5)), 3'($urandom_range(5)), 3'($urandom_range(5)),
                     3'($urandom_range(5)), 1'($urandom), ($urandom_range(3) != 0));
            if (sys_rst_req) do_reset();
            else go_sleep();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule